// File: doc/BRIEF.md
# B1 Parity Monitor and Descrambler

This block sits on the receive side of a SONET/SDH line interface, after framing. It takes a byte stream with a frame-start strobe and produces a descrambled copy of the stream one cycle later. Alongside, it runs a BIP-8 over the raw, still-scrambled bytes of every frame and keeps the result. One frame later, it compares that stored value against the descrambled B1 byte of the frame that follows.

Each comparison gives an 8-bit error mask with a one-cycle valid strobe. A de-interleaver downstream can take the mask for its tributary parity bytes. The set bits of each mask also go into a saturating error counter, which feeds bit-error-rate monitoring. Reading the counter clears it.

The descrambler is the frame-synchronous x^7+x^6+1 generator. It restarts at each frame start. A configurable count of leading bytes in every frame is left unscrambled.

Top module: `b1_parity_mon`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `out_valid` is 0, `mask_valid` is 0 and `err_count` is 0.
- R2: Each byte accepted with `in_valid` appears on `out_data` one cycle later, with `out_sof` copying `in_sof`. The byte index is 0 for a byte accepted with `in_sof` and increases by one for each later accepted byte. Bytes with index below `UNSCR_LEN`, and bytes accepted before the first frame start after reset, pass through unchanged.
- R3: A byte with index k >= `UNSCR_LEN` is XORed with keystream byte number k-`UNSCR_LEN`. The keystream is a bit sequence b with b[0..6]=1 and b[n]=b[n-7]^b[n-6]. Keystream byte j takes bits 8j..8j+7, with bit 8j in data bit 7. The sequence restarts at every frame start.
- R4: The parity of a frame is the XOR of all raw (not yet descrambled) bytes from its start byte up to, but not including, the next start byte. It is captured when that next start byte is accepted.
- R5: When the byte with index `B1_POS` is output and a captured parity exists, `mask_valid` pulses for that one cycle. `mask` then equals the descrambled byte XOR the captured parity.
- R6: No mask is produced in the first frame after reset, since no parity has been captured yet.
- R7: A frame with fewer than `B1_POS`+1 bytes produces no mask. Its parity is still captured and used to check the next frame.
- R8: One cycle after `mask_valid`, `err_count` grows by the number of ones in `mask`. Without a mask or a read, it holds.
- R9: `err_count` saturates at 2^`CNT_W`-1 and never wraps.
- R10: A cycle with `cnt_rd` high clears `err_count` on the next cycle. A mask reported in that same cycle is counted into the cleared value.
- R11: Cycles with `in_valid` low produce `out_valid` low on the next cycle and leave the byte index, keystream and parity state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | Input byte is the first byte of a frame (qualified by in_valid) |
| in_data | input | 8 | Scrambled line byte |
| cnt_rd | input | 1 | Read strobe; clears the error counter |
| out_valid | output | 1 | Output byte present |
| out_sof | output | 1 | Output byte is a frame start |
| out_data | output | 8 | Descrambled byte |
| mask_valid | output | 1 | B1 error mask valid this cycle |
| mask | output | 8 | B1 error mask (ones mark failing parity lanes) |
| err_count | output | CNT_W | Saturating count of mask bits set |

## Verification
The assertions check several things on every cycle:
- the valid and start strobes follow the input one cycle later, and idle cycles yield no output;
- a mask never appears before two frame starts, never lasts two cycles, and always coincides with a non-start output byte;
- the counter holds, clears or stays saturated as its inputs dictate.

Only the bench scenarios can show that the descrambled values, the parity and the mask bits are correct. It does this by building frames whose B1 byte carries a chosen error pattern. The same scenarios cover short frames, reads that coincide with a mask, and saturation of the counter.

// File: rtl/b1m_pkg.sv
package b1m_pkg;

    localparam logic [6:0] PN_SEED = 7'h7F;

    typedef struct packed {
        logic [7:0] ks;
        logic [6:0] nxt;
    } pn_step_t;

    typedef struct packed {
        logic       vld;
        logic       sof;
        logic [7:0] data;
    } beat_t;

    typedef struct packed {
        logic       vld;
        logic [7:0] bits;
    } mask_t;

    // Eight steps of the x^7+x^6+1 generator, first bit into data bit 7.
    function automatic pn_step_t pn_byte(input logic [6:0] s);
        pn_step_t   r;
        logic [6:0] t;
        t = s;
        r.ks = '0;
        for (int b = 7; b >= 0; b--) begin
            r.ks[b] = t[6];
            t = {t[5:0], t[6] ^ t[5]};
        end
        r.nxt = t;
        return r;
    endfunction

    function automatic logic [3:0] ones8(input logic [7:0] v);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < 8; i++) begin
            n = n + {3'b000, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/b1m_descrambler.sv
module b1m_descrambler
    import b1m_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       adv,
    input  logic [7:0] din,
    output logic [7:0] dout
);
    logic [6:0] st_q;
    logic [6:0] seed;
    pn_step_t   step;

    always_comb begin
        seed = restart ? PN_SEED : st_q;
        step = pn_byte(seed);
        dout = adv ? (din ^ step.ks) : din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= PN_SEED;
        end else if (adv) begin
            st_q <= step.nxt;
        end else if (restart) begin
            st_q <= PN_SEED;
        end
    end
endmodule

// File: rtl/b1m_bip8.sv
module b1m_bip8 (
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       sof,
    input  logic [7:0] din,
    output logic [7:0] par,
    output logic       par_ok
);
    logic [7:0] acc_q;
    logic       open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            par    <= '0;
            par_ok <= 1'b0;
            open_q <= 1'b0;
        end else if (take) begin
            open_q <= 1'b1;
            acc_q  <= sof ? din : (acc_q ^ din);
            if (sof && open_q) begin
                par    <= acc_q;
                par_ok <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/b1m_errcnt.sv
module b1m_errcnt
    import b1m_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             hit,
    input  logic [7:0]       bits,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [3:0]     add;
    logic [CNT_W:0] sum;

    always_comb begin
        add = hit ? ones8(bits) : 4'd0;
        sum = {1'b0, (clr ? '0 : count)} + {{(CNT_W - 3){1'b0}}, add};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            count <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/b1_parity_mon.sv
module b1_parity_mon
    import b1m_pkg::*;
#(
    parameter int UNSCR_LEN = 9,
    parameter int B1_POS    = 90,
    parameter int IDX_W     = 16,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [7:0]       in_data,
    input  logic             cnt_rd,
    output logic             out_valid,
    output logic             out_sof,
    output logic [7:0]       out_data,
    output logic             mask_valid,
    output logic [7:0]       mask,
    output logic [CNT_W-1:0] err_count
);
    localparam logic [IDX_W-1:0] UNSCR_IDX = IDX_W'(UNSCR_LEN);
    localparam logic [IDX_W-1:0] B1_IDX    = IDX_W'(B1_POS);
    localparam logic [IDX_W-1:0] IDX_MAX   = '1;

    logic [IDX_W-1:0] pos_q;
    logic [IDX_W-1:0] cur_idx;
    logic             frm_q;
    logic             take_byte;
    logic             scr;
    logic [7:0]       plain;
    logic [7:0]       par;
    logic             par_ok;
    beat_t            beat_q;
    mask_t            mask_q;

    always_comb begin
        cur_idx   = in_sof ? '0 : pos_q;
        take_byte = in_valid && (in_sof || frm_q);
        scr       = take_byte && (cur_idx >= UNSCR_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            frm_q <= 1'b0;
        end else if (take_byte) begin
            frm_q <= 1'b1;
            pos_q <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
        end
    end

    b1m_descrambler u_descr (
        .clk    (clk),
        .rst    (rst),
        .restart(in_valid && in_sof),
        .adv    (scr),
        .din    (in_data),
        .dout   (plain)
    );

    b1m_bip8 u_bip (
        .clk   (clk),
        .rst   (rst),
        .take  (take_byte),
        .sof   (in_sof),
        .din   (in_data),
        .par   (par),
        .par_ok(par_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            mask_q <= '0;
        end else begin
            beat_q.vld  <= in_valid;
            beat_q.sof  <= in_valid && in_sof;
            beat_q.data <= plain;
            mask_q.vld  <= take_byte && par_ok && (cur_idx == B1_IDX);
            if (take_byte && par_ok && (cur_idx == B1_IDX)) begin
                mask_q.bits <= plain ^ par;
            end
        end
    end

    b1m_errcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_rd),
        .hit  (mask_q.vld),
        .bits (mask_q.bits),
        .count(err_count)
    );

    assign out_valid  = beat_q.vld;
    assign out_sof    = beat_q.sof;
    assign out_data   = beat_q.data;
    assign mask_valid = mask_q.vld;
    assign mask       = mask_q.bits;
endmodule

// File: rtl/b1m_chk.sv
module b1m_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_sof,
    input logic             cnt_rd,
    input logic             out_valid,
    input logic             out_sof,
    input logic             mask_valid,
    input logic [CNT_W-1:0] err_count
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [1:0] starts_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            starts_q <= '0;
        end else if (in_valid && in_sof && starts_q != 2'd2) begin
            starts_q <= starts_q + 2'd1;
        end
    end

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R2
    sof_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof) |=> out_sof);
    // R2
    sof_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid);
    // R5
    mask_on_byte_chk: assert property (@(posedge clk) disable iff (rst)
        mask_valid |-> (out_valid && !out_sof));
    // R5
    mask_single_chk: assert property (@(posedge clk) disable iff (rst)
        mask_valid |=> !mask_valid);
    // R6
    no_early_mask_chk: assert property (@(posedge clk) disable iff (rst)
        mask_valid |-> (starts_q == 2'd2));
    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnt_rd && !mask_valid) |=> $stable(err_count));
    // R8
    count_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_rd |=> (err_count >= $past(err_count)));
    // R9
    count_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnt_rd && err_count == CMAX) |=> (err_count == CMAX));
    // R10
    count_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_rd && !mask_valid) |=> (err_count == '0));
endmodule

bind b1_parity_mon b1m_chk #(.CNT_W(CNT_W)) u_b1m_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .cnt_rd    (cnt_rd),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .mask_valid(mask_valid),
    .err_count (err_count)
);

// File: tb/tb_b1_parity_mon.sv
`timescale 1ns/1ps
module tb_b1_parity_mon;
    localparam int UNSCR = 9;
    localparam int B1P   = 90;
    localparam int CW    = 6;
    localparam int CMAX  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_sof = 1'b0;
    logic [7:0]    in_data = '0;
    logic          cnt_rd = 1'b0;
    logic          out_valid;
    logic          out_sof;
    logic [7:0]    out_data;
    logic          mask_valid;
    logic [7:0]    mask;
    logic [CW-1:0] err_count;

    always #2.5 clk = ~clk;

    b1_parity_mon #(.UNSCR_LEN(UNSCR), .B1_POS(B1P), .IDX_W(16), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .cnt_rd(cnt_rd), .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data),
        .mask_valid(mask_valid), .mask(mask), .err_count(err_count)
    );

    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 0;
    logic [7:0] ks [0:255];
    logic [7:0] prev_par = '0;
    bit         have_par = 0;
    int         exp_cnt = 0;
    int         pend_add = 0;
    int         force_rd_at = -1;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ones(logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic void build_ks();
        bit b [0:2047];
        for (int n = 0; n < 2048; n++) b[n] = (n < 7) ? 1'b1 : (b[n-7] ^ b[n-6]);
        for (int k = 0; k < 256; k++)
            for (int j = 0; j < 8; j++) ks[k][7-j] = b[8*k + j];
    endfunction

    task automatic step(bit v, bit s, logic [7:0] d, bit rd, logic [7:0] exp_d,
                        bit exp_mv, logic [7:0] exp_m, string dtag, string mtag);
        in_valid = v; in_sof = s; in_data = d; cnt_rd = rd;
        @(negedge clk);
        check(out_valid == v, "R11", "out_valid", int'(out_valid), int'(v));
        if (v) begin
            check(out_sof == s, "R2", "out_sof", int'(out_sof), int'(s));
            check(out_data == exp_d, dtag, "out_data", int'(out_data), int'(exp_d));
        end
        check(mask_valid == exp_mv, mtag, "mask_valid", int'(mask_valid), int'(exp_mv));
        if (exp_mv) check(mask == exp_m, mtag, "mask", int'(mask), int'(exp_m));
        exp_cnt = (rd ? 0 : exp_cnt) + pend_add;
        if (exp_cnt > CMAX) exp_cnt = CMAX;
        check(int'(err_count) == exp_cnt, rd ? "R10" : "R8", "err_count",
              int'(err_count), exp_cnt);
        pend_add = exp_mv ? ones(exp_m) : 0;
    endtask

    task automatic idle(bit rd);
        step(1'b0, 1'b0, 8'($urandom), rd, 8'h00, 1'b0, 8'h00, "R11", "R11");
    endtask

    task automatic send_frame(int len, logic [7:0] inj, int gap_pct, int rd_pct, string mtag);
        logic [7:0] raw [0:255];
        logic [7:0] par = '0;
        for (int i = 0; i < 256; i++) raw[i] = 8'($urandom);
        if (len > B1P && have_par) raw[B1P] = prev_par ^ inj ^ ks[B1P - UNSCR];
        for (int i = 0; i < len; i++) begin
            bit         rd;
            logic [7:0] exp_d;
            while (int'($urandom_range(99)) < gap_pct)
                idle(int'($urandom_range(99)) < rd_pct);
            rd    = (int'($urandom_range(99)) < rd_pct) || (i == force_rd_at);
            exp_d = (i >= UNSCR) ? (raw[i] ^ ks[i - UNSCR]) : raw[i];
            step(1'b1, i == 0, raw[i], rd, exp_d, (i == B1P) && have_par, inj,
                 (i >= UNSCR) ? "R2 R3" : "R2", mtag);
            par ^= raw[i];
        end
        prev_par = par;
        have_par = 1;
    endtask

    initial begin
        void'($urandom(32'd1777));
        build_ks();
        repeat (3) @(negedge clk);
        // R1: state during reset
        check(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
        check(mask_valid == 1'b0, "R1", "mask_valid", int'(mask_valid), 0);
        check(err_count == '0, "R1", "err_count", int'(err_count), 0);
        rst = 1'b0;
        // bytes before any frame start pass through unchanged (R2), no mask (R6)
        for (int i = 0; i < 5; i++) begin
            logic [7:0] g = 8'($urandom);
            step(1'b1, 1'b0, g, 1'b0, g, 1'b0, 8'h00, "R2", "R6");
        end
        send_frame(120, 8'h00, 0, 0, "R6");
        send_frame(130, 8'h00, 10, 0, "R4 R5");
        for (int f = 0; f < 12; f++)
            send_frame(95 + int'($urandom_range(85)), 8'($urandom), 20, 5, "R4 R5");
        send_frame(110, 8'h81, 60, 0, "R11");
        // R7: short frame, then its parity checks the next frame
        send_frame(50, 8'h00, 10, 0, "R7");
        send_frame(140, 8'h3C, 10, 0, "R7");
        idle(1'b1);
        idle(1'b0);
        // R10: read in the same cycle as a mask
        force_rd_at = B1P + 1;
        send_frame(120, 8'h5A, 0, 0, "R5");
        force_rd_at = -1;
        idle(1'b0);
        check(int'(err_count) == 4, "R10", "count after coincident read", int'(err_count), 4);
        // R9: saturation
        idle(1'b1);
        for (int f = 0; f < 9; f++) send_frame(100, 8'hFF, 0, 0, "R9");
        idle(1'b0);
        check(int'(err_count) == CMAX, "R9", "saturated count", int'(err_count), CMAX);
        idle(1'b1);
        idle(1'b0);
        check(err_count == '0, "R10", "count after read", int'(err_count), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule